// File: doc/BRIEF.md
# Read Line Buffer Replacement Selector

This block keeps the bookkeeping for four read line buffers placed in front of a slow memory array. For each buffer it holds a valid flag, a line tag and a rank in a full recency order. The data storage and the array timing live elsewhere. Given a lookup tag and an access type, the block reports at once whether a buffer in the allowed set holds that line. It also names the buffer to load if the line has to be fetched.

Completed fills are reported back to the block, marked either as a demand miss fill or a speculative next-line fill. The two kinds change the recency order differently, so speculatively loaded lines do not push out lines that are really in use. A two-bit partition mode limits which buffers instruction and data accesses may use. An invalidate-all empties the whole set in one cycle.

Top module: `lbuf_repl_sel`

## Requirements
- R1: After reset, no buffer is valid, `hit_o` is 0 and `victim_o` is 0 in pooled mode. `hit_idx_o` is 0 whenever `hit_o` is 0.
- R2: If any eligible buffer is invalid, `victim_o` names the lowest-numbered invalid eligible buffer.
- R3: If every eligible buffer is valid, `victim_o` names the eligible buffer with the oldest rank. Ranks form a permutation of 0 (oldest) to 3 (youngest).
- R4: A demand fill (`fill_i`=1, `fill_pref_i`=0) makes buffer `fill_idx_i` valid with tag `fill_tag_i` and gives it the youngest rank. Only buffers younger than its old rank age by one.
- R5: A prefetch fill (`fill_pref_i`=1) makes the buffer valid with the new tag and leaves every rank unchanged. A later lookup hit on it makes it youngest.
- R6: Partition mode encoding is 2'b00 or 2'b11 for pooled, where all four buffers are eligible for both access types.
- R7: Mode 2'b01: instruction accesses (`acc_instr_i`=1) may use buffers 0 and 1 only, and data accesses may use buffers 2 and 3 only.
- R8: Mode 2'b10: instruction accesses may use buffers 0, 1 and 2, and data accesses may use buffer 3 only.
- R9: `hit_o` is 1 in the same cycle only if an eligible, valid buffer holds `lookup_tag_i`. `hit_idx_o` then names it.
- R10: `inval_all_i` clears every valid flag and restores ranks 0,1,2,3 for buffers 0..3 at the next edge. It overrides a fill or a lookup in the same cycle.
- R11: A lookup (`lookup_vld_i`=1) that hits promotes the hit buffer to youngest. A lookup that misses changes no rank. When a fill and a lookup occur in the same cycle, the fill is applied and the lookup promotion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| part_mode_i | input | 2 | Partition mode |
| acc_instr_i | input | 1 | 1 = instruction access, 0 = data access |
| lookup_tag_i | input | TAG_W | Line tag being looked up |
| lookup_vld_i | input | 1 | A real read lookup this cycle (promotes on hit) |
| fill_i | input | 1 | A buffer fill completes this cycle |
| fill_pref_i | input | 1 | 1 = prefetch fill, 0 = demand fill |
| fill_idx_i | input | 2 | Buffer being filled |
| fill_tag_i | input | TAG_W | Tag written by the fill |
| inval_all_i | input | 1 | Invalidate every buffer |
| hit_o | output | 1 | Lookup hit |
| hit_idx_o | output | 2 | Index of the hitting buffer |
| victim_o | output | 2 | Buffer to load on a miss |

## Verification
The assertions assume that the surrounding controller fills only a buffer inside the eligible set for the current mode and type. They also assume it never fills a tag that another valid eligible buffer already holds, so at most one buffer can match. Partition mode is taken to be stable whenever it matters for a decision. The stimulus keeps to these rules: each fill targets the victim the block has just named, or an index in the matching partition, with distinct tags. Mode changes happen only on idle cycles between lookups.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  localparam int unsigned NBUF  = 4;
  localparam int unsigned IDX_W = $clog2(NBUF);
  localparam int unsigned AGE_W = $clog2(NBUF);

  typedef logic [IDX_W-1:0]            idx_t;
  typedef logic [NBUF-1:0]             mask_t;
  typedef logic [NBUF-1:0][AGE_W-1:0]  age_vec_t;

  typedef enum logic [1:0] {
    PM_POOL      = 2'b00,
    PM_SPLIT_2_2 = 2'b01,
    PM_SPLIT_3_1 = 2'b10,
    PM_POOL_ALT  = 2'b11
  } part_mode_e;

  localparam int unsigned YOUNGEST = NBUF - 1;
endpackage

// File: rtl/lbuf_elig.sv
module lbuf_elig
  import lbuf_pkg::*;
(
  input  logic [1:0] part_mode_i,
  input  logic       acc_instr_i,
  output mask_t      elig_o
);
  logic       pooled;
  logic [2:0] instr_cnt;

  always_comb begin
    pooled    = 1'b0;
    instr_cnt = 3'(NBUF);
    unique case (part_mode_e'(part_mode_i))
      PM_SPLIT_2_2: instr_cnt = 3'd2;
      PM_SPLIT_3_1: instr_cnt = 3'd3;
      default:      pooled    = 1'b1;
    endcase
  end

  for (genvar i = 0; i < NBUF; i++) begin : g_elig
    always_comb begin
      if (pooled)           elig_o[i] = 1'b1;
      else if (acc_instr_i) elig_o[i] = (3'(i) < instr_cnt);
      else                  elig_o[i] = (3'(i) >= instr_cnt);
    end
  end
endmodule

// File: rtl/lbuf_lookup.sv
module lbuf_lookup
  import lbuf_pkg::*;
#(
  parameter int unsigned TAG_W = 16
) (
  input  logic [NBUF-1:0][TAG_W-1:0] tag_i,
  input  mask_t                      valid_i,
  input  mask_t                      elig_i,
  input  logic [TAG_W-1:0]           lookup_tag_i,
  output logic                       hit_o,
  output idx_t                       hit_idx_o
);
  mask_t match;

  for (genvar i = 0; i < NBUF; i++) begin : g_cmp
    assign match[i] = valid_i[i] & elig_i[i] & (tag_i[i] == lookup_tag_i);
  end

  assign hit_o = |match;

  // OR-encode; at most one match by contract
  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (match[i]) hit_idx_o = hit_idx_o | idx_t'(i);
    end
  end
endmodule

// File: rtl/lbuf_age.sv
module lbuf_age
  import lbuf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     inval_i,
  input  logic     promote_i,
  input  idx_t     promote_idx_i,
  output age_vec_t age_o
);
  age_vec_t          age_q;
  logic [AGE_W-1:0]  pivot;

  assign pivot = age_q[promote_idx_i];

  for (genvar j = 0; j < NBUF; j++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[j] <= AGE_W'(j);
      end else if (inval_i) begin
        age_q[j] <= AGE_W'(j);
      end else if (promote_i) begin
        if (idx_t'(j) == promote_idx_i) age_q[j] <= AGE_W'(YOUNGEST);
        else if (age_q[j] > pivot)      age_q[j] <= age_q[j] - 1'b1;
      end
    end
  end

  assign age_o = age_q;
endmodule

// File: rtl/lbuf_victim.sv
module lbuf_victim
  import lbuf_pkg::*;
(
  input  mask_t    valid_i,
  input  mask_t    elig_i,
  input  age_vec_t age_i,
  output idx_t     victim_o
);
  mask_t            free;
  idx_t             free_idx;
  idx_t             lru_idx;
  logic [AGE_W-1:0] lru_age;
  logic             lru_seen;

  assign free = elig_i & ~valid_i;

  // lowest index wins: scan downward
  always_comb begin
    free_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (free[i]) free_idx = idx_t'(i);
    end
  end

  always_comb begin
    lru_idx  = '0;
    lru_age  = '1;
    lru_seen = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (elig_i[i] && (!lru_seen || age_i[i] < lru_age)) begin
        lru_idx  = idx_t'(i);
        lru_age  = age_i[i];
        lru_seen = 1'b1;
      end
    end
  end

  assign victim_o = (|free) ? free_idx : lru_idx;
endmodule

// File: rtl/lbuf_repl_sel.sv
module lbuf_repl_sel
  import lbuf_pkg::*;
#(
  parameter int unsigned TAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       part_mode_i,
  input  logic             acc_instr_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  input  logic             lookup_vld_i,
  input  logic             fill_i,
  input  logic             fill_pref_i,
  input  logic [1:0]       fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             inval_all_i,
  output logic             hit_o,
  output logic [1:0]       hit_idx_o,
  output logic [1:0]       victim_o
);
  mask_t                      valid_q;
  logic [NBUF-1:0][TAG_W-1:0] tag_q;
  age_vec_t                   age_q;
  mask_t                      elig;
  logic                       hit;
  idx_t                       hit_idx;
  logic                       promote;
  idx_t                       promote_idx;

  lbuf_elig u_elig (
    .part_mode_i (part_mode_i),
    .acc_instr_i (acc_instr_i),
    .elig_o      (elig)
  );

  lbuf_lookup #(.TAG_W(TAG_W)) u_lookup (
    .tag_i        (tag_q),
    .valid_i      (valid_q),
    .elig_i       (elig),
    .lookup_tag_i (lookup_tag_i),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx)
  );

  // fill outranks lookup promotion; prefetch fill does not promote
  assign promote     = !inval_all_i &&
                       (fill_i ? !fill_pref_i : (lookup_vld_i && hit));
  assign promote_idx = fill_i ? idx_t'(fill_idx_i) : hit_idx;

  lbuf_age u_age (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .inval_i       (inval_all_i),
    .promote_i     (promote),
    .promote_idx_i (promote_idx),
    .age_o         (age_q)
  );

  lbuf_victim u_victim (
    .valid_i  (valid_q),
    .elig_i   (elig),
    .age_i    (age_q),
    .victim_o (victim_o)
  );

  for (genvar i = 0; i < NBUF; i++) begin : g_line
    logic wr;
    assign wr = fill_i && (idx_t'(fill_idx_i) == idx_t'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          valid_q[i] <= 1'b0;
      else if (inval_all_i) valid_q[i] <= 1'b0;
      else if (wr)          valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  tag_q[i] <= '0;
      else if (wr && !inval_all_i)  tag_q[i] <= fill_tag_i;
    end
  end

  assign hit_o     = hit;
  assign hit_idx_o = hit_idx;
endmodule

// File: rtl/lbuf_repl_sel_chk.sv
module lbuf_repl_sel_chk
  import lbuf_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] part_mode_i,
  input logic       acc_instr_i,
  input logic       lookup_vld_i,
  input logic       fill_i,
  input logic       fill_pref_i,
  input logic [1:0] fill_idx_i,
  input logic       inval_all_i,
  input logic       hit_o,
  input logic [1:0] hit_idx_o,
  input logic [1:0] victim_o,
  input mask_t      valid_q,
  input age_vec_t   age_q
);
  logic [NBUF-1:0] allow;
  always_comb begin
    case (part_mode_i)
      2'b01:   allow = acc_instr_i ? 4'b0011 : 4'b1100;
      2'b10:   allow = acc_instr_i ? 4'b0111 : 4'b1000;
      default: allow = 4'b1111;
    endcase
  end

  for (genvar k = 0; k < NBUF; k++) begin : g_perm
    logic [NBUF-1:0] holder;
    for (genvar j = 0; j < NBUF; j++) begin : g_h
      assign holder[j] = (age_q[j] == AGE_W'(k));
    end
    a_age_perm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(holder) == 1);
  end

  a_victim_allowed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow[victim_o]);

  a_victim_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(allow & ~valid_q)) |-> !valid_q[victim_o]);

  a_hit_ok_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid_q[hit_idx_o] && allow[hit_idx_o]));

  a_demand_mru_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !fill_pref_i && !inval_all_i) |=>
      (age_q[$past(fill_idx_i)] == AGE_W'(YOUNGEST)) && valid_q[$past(fill_idx_i)]);

  a_pref_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && fill_pref_i && !inval_all_i) |=> $stable(age_q));

  a_miss_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_vld_i && !hit_o && !fill_i && !inval_all_i) |=> $stable(age_q));

  a_inval_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_all_i |=> (valid_q == '0) && (age_q == {2'd3, 2'd2, 2'd1, 2'd0}));
endmodule

bind lbuf_repl_sel lbuf_repl_sel_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .part_mode_i  (part_mode_i),
  .acc_instr_i  (acc_instr_i),
  .lookup_vld_i (lookup_vld_i),
  .fill_i       (fill_i),
  .fill_pref_i  (fill_pref_i),
  .fill_idx_i   (fill_idx_i),
  .inval_all_i  (inval_all_i),
  .hit_o        (hit_o),
  .hit_idx_o    (hit_idx_o),
  .victim_o     (victim_o),
  .valid_q      (valid_q),
  .age_q        (age_q)
);

// File: tb/lbuf_repl_sel_tb.sv
module lbuf_repl_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W      = 16;

  localparam logic [1:0] OP_NOP = 2'd0, OP_LOOK = 2'd1, OP_FILL = 2'd2, OP_INV = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  mode;
    logic        instr;
    logic [1:0]  idx;
    logic [15:0] tag;
    logic        pref;
    logic        ehit;
    logic [1:0]  ehidx;
    logic [1:0]  evic;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  // outputs are checked before the op takes effect at the following edge
  localparam vec_t VEC [NV] = '{
    '{OP_NOP , 2'b00, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 2'd0, 8'd1 },  // R1
    '{OP_FILL, 2'b00, 1'b0, 2'd0, 16'h0100, 1'b0, 1'b0, 2'd0, 2'd0, 8'd2 },  // R2 R4
    '{OP_FILL, 2'b00, 1'b1, 2'd1, 16'h0101, 1'b1, 1'b0, 2'd0, 2'd1, 8'd2 },  // R2 R5
    '{OP_FILL, 2'b00, 1'b0, 2'd2, 16'h0102, 1'b0, 1'b0, 2'd0, 2'd2, 8'd2 },  // R2
    '{OP_FILL, 2'b00, 1'b0, 2'd3, 16'h0103, 1'b0, 1'b0, 2'd0, 2'd3, 8'd4 },  // R4
    '{OP_NOP , 2'b00, 1'b1, 2'd0, 16'h0200, 1'b0, 1'b0, 2'd0, 2'd1, 8'd5 },  // R5 prefetched still oldest
    '{OP_LOOK, 2'b00, 1'b1, 2'd0, 16'h0101, 1'b0, 1'b1, 2'd1, 2'd1, 8'd9 },  // R9 R5 hit promotes
    '{OP_NOP , 2'b00, 1'b1, 2'd0, 16'h0300, 1'b0, 1'b0, 2'd0, 2'd0, 8'd3 },  // R3
    '{OP_LOOK, 2'b00, 1'b1, 2'd0, 16'h0300, 1'b0, 1'b0, 2'd0, 2'd0, 8'd11},  // R11 miss
    '{OP_NOP , 2'b01, 1'b1, 2'd0, 16'h0102, 1'b0, 1'b0, 2'd0, 2'd0, 8'd7 },  // R7
    '{OP_NOP , 2'b01, 1'b0, 2'd0, 16'h0102, 1'b0, 1'b1, 2'd2, 2'd2, 8'd7 },  // R7
    '{OP_NOP , 2'b10, 1'b1, 2'd0, 16'h0103, 1'b0, 1'b0, 2'd0, 2'd0, 8'd8 },  // R8
    '{OP_NOP , 2'b10, 1'b0, 2'd0, 16'h0103, 1'b0, 1'b1, 2'd3, 2'd3, 8'd8 },  // R8
    '{OP_LOOK, 2'b10, 1'b1, 2'd0, 16'h0100, 1'b0, 1'b1, 2'd0, 2'd0, 8'd11},  // R11
    '{OP_NOP , 2'b10, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 2'd2, 8'd3 },  // R3 R8
    '{OP_NOP , 2'b11, 1'b0, 2'd0, 16'h0101, 1'b0, 1'b1, 2'd1, 2'd2, 8'd6 },  // R6
    '{OP_INV , 2'b00, 1'b1, 2'd0, 16'h0100, 1'b0, 1'b1, 2'd0, 2'd2, 8'd10},  // R10
    '{OP_NOP , 2'b00, 1'b1, 2'd0, 16'h0100, 1'b0, 1'b0, 2'd0, 2'd0, 8'd10},  // R10
    '{OP_FILL, 2'b01, 1'b0, 2'd3, 16'h0055, 1'b1, 1'b0, 2'd0, 2'd2, 8'd7 },  // R7 R2
    '{OP_NOP , 2'b01, 1'b0, 2'd0, 16'h0055, 1'b0, 1'b1, 2'd3, 2'd2, 8'd2 },  // R2
    '{OP_NOP , 2'b01, 1'b1, 2'd0, 16'h0055, 1'b0, 1'b0, 2'd0, 2'd0, 8'd9 }   // R9
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       part_mode = '0;
  logic             acc_instr = 1'b0;
  logic [TAG_W-1:0] lookup_tag = '0;
  logic             lookup_vld = 1'b0;
  logic             fill = 1'b0;
  logic             fill_pref = 1'b0;
  logic [1:0]       fill_idx = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic             inval_all = 1'b0;
  logic             hit;
  logic [1:0]       hit_idx;
  logic [1:0]       victim;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbuf_repl_sel #(.TAG_W(TAG_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .part_mode_i  (part_mode),
    .acc_instr_i  (acc_instr),
    .lookup_tag_i (lookup_tag),
    .lookup_vld_i (lookup_vld),
    .fill_i       (fill),
    .fill_pref_i  (fill_pref),
    .fill_idx_i   (fill_idx),
    .fill_tag_i   (fill_tag),
    .inval_all_i  (inval_all),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx),
    .victim_o     (victim)
  );

  task automatic check(input string what, input int req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input int req, input logic eh, input logic [1:0] ei,
                            input logic [1:0] ev);
    check("hit", req, int'(hit), int'(eh));
    check("hit_idx", req, int'(hit_idx), eh ? int'(ei) : 0);
    check("victim", req, int'(victim), int'(ev));
  endtask

  task automatic idle();
    lookup_vld = 1'b0; fill = 1'b0; fill_pref = 1'b0; inval_all = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 expect_out(1, 1'b0, 2'd0, 2'd0);  // R1 during reset
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle();
      part_mode  = VEC[v].mode;
      acc_instr  = VEC[v].instr;
      lookup_tag = VEC[v].tag;
      fill_idx   = VEC[v].idx;
      fill_tag   = VEC[v].tag;
      fill_pref  = VEC[v].pref;
      case (VEC[v].op)
        OP_LOOK: lookup_vld = 1'b1;
        OP_FILL: fill       = 1'b1;
        OP_INV:  inval_all  = 1'b1;
        default: ;
      endcase
      #1 expect_out(int'(VEC[v].req), VEC[v].ehit, VEC[v].ehidx, VEC[v].evic);
    end

    // R10: invalidate beats a fill in the same cycle
    @(negedge clk); idle(); part_mode = 2'b00; acc_instr = 1'b1;
    fill = 1'b1; fill_idx = 2'd0; fill_tag = 16'h0777; inval_all = 1'b1;
    @(negedge clk); idle(); lookup_tag = 16'h0777;
    #1 expect_out(10, 1'b0, 2'd0, 2'd0);

    // R11: fill outranks lookup promotion; demand-fill all to ranks 0..3
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); idle();
      fill = 1'b1; fill_idx = 2'(b); fill_tag = 16'h0A00 + 16'(b);
    end
    @(negedge clk); idle(); lookup_tag = 16'h0A00;
    #1 expect_out(4, 1'b1, 2'd0, 2'd0);  // R4 order 0 oldest
    lookup_vld = 1'b1;
    fill = 1'b1; fill_pref = 1'b1; fill_idx = 2'd1; fill_tag = 16'h0B01;
    @(negedge clk); idle(); lookup_tag = 16'h0B01;
    #1 expect_out(11, 1'b1, 2'd1, 2'd0);  // R11 no promotion of 0, R5 no rank change

    // R5: hit on prefetched buffer 1 promotes it; then 0 promoted, victim 2
    lookup_vld = 1'b1;
    @(negedge clk); idle(); lookup_tag = 16'h0A00; lookup_vld = 1'b1;
    @(negedge clk); idle();
    #1 expect_out(5, 1'b1, 2'd0, 2'd2);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1 expect_out(1, 1'b0, 2'd0, 2'd0);
    @(negedge clk); rst_n = 1'b1;
    lookup_tag = 16'h0A02;
    #1 expect_out(1, 1'b0, 2'd0, 2'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule